// File: doc/BRIEF.md
# Full-Period LFSR Sequence Counter

This block is a forward-only counter whose register steps through a shift-register sequence instead of a binary adder. The base feedback is the parity of a tap mask that describes a maximal-length polynomial. On its own, that sequence visits 2**WIDTH - 1 states. An extra correction term splices the all-zero state into the cycle, so the counter walks through every WIDTH-bit value exactly once in each period of 2**WIDTH steps. That makes it suitable wherever a full-range wrap-around pointer is needed and adder carry logic is unwanted.

Positions are given to the block as plain integer step counts. The reset position and the compare position are each translated during elaboration into the register value found that many steps after the all-zero seed. There is no closed form for this translation, so a constant function iterates the step function to find it. The match output compares the register against the translated value, never against the binary encoding of the index. The block has no data stream; enable and match are plain control and status pins.

Top module: `lfsr_fullcycle_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` loads the value reached after START_INDEX steps from the all-zero state (index 0 is all zeros), and `match` is cleared to 0.
- R2: When `en` is low and `rst` is low, `state` keeps its value across the clock edge.
- R3: When `en` is high, one step is taken per clock: the new value is `state >> 1` with bit WIDTH-1 set to parity(`state` & TAPS) XOR (`state[WIDTH-1:1]` == 0).
- R4: With `en` held high, `state` returns to any value after exactly 2**WIDTH steps and shows every WIDTH-bit value exactly once in between.
- R5: The all-zero state is part of the cycle: value 1 steps to 0, and 0 steps to the value with only bit WIDTH-1 set.
- R6: `match` is registered. It is 1 in the cycle after a clock edge at which `state` equalled the MATCH_INDEX state (the value after MATCH_INDEX steps from zero), whatever the level of `en`, and 0 otherwise.
- R7: `match` stays 0 after `state` holds the binary value of MATCH_INDEX, whenever that value differs from the MATCH_INDEX state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance one sequence step this cycle |
| state | output | WIDTH | Current register value |
| match | output | 1 | Registered flag: previous state equalled the compare state |

## Verification
The hardest condition to reach is the spliced transition through zero, together with the wrap back to the start value. They occur only once per period, after about 2**WIDTH enabled cycles. The bench therefore holds enable high for a full period of the 8-bit instance. It also runs a 4-bit instance whose reset index sits one step before the zero state, so that the splice occurs on the very first enabled cycle and recurs every 16 steps. A compare index whose binary value appears elsewhere in the sequence exercises the translated comparison.

// File: rtl/lfsr_seq_pkg.sv
package lfsr_seq_pkg;

  // one forward step of the extended sequence, width w, tap mask taps
  function automatic logic [31:0] seq_step(input int w, input logic [31:0] taps,
                                           input logic [31:0] cur);
    logic [31:0] msk;
    logic [31:0] s;
    logic        fb;
    msk = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    s   = cur & msk;
    fb  = ^(s & taps);
    if ((s >> 1) == 32'd0) fb = ~fb;
    return ((s >> 1) | (32'(fb) << (w - 1))) & msk;
  endfunction

  // value held after k steps from the all-zero seed
  function automatic logic [31:0] seq_at(input int w, input logic [31:0] taps,
                                         input int k);
    logic [31:0] s;
    s = 32'd0;
    for (int i = 0; i < k; i++) s = seq_step(w, taps, s);
    return s;
  endfunction

endpackage

// File: rtl/lfsr_next_logic.sv
module lfsr_next_logic #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h1D
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] tapped;
  logic             upper_zero;
  logic             fb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = cur[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign upper_zero = (cur[WIDTH-1:1] == '0);
  assign fb         = (^tapped) ^ upper_zero;
  assign nxt        = {fb, cur[WIDTH-1:1]};
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)     cur <= INIT;
    else if (en) cur <= nxt;
  end

  assert_reset_load_R1: assert property (@(posedge clk) rst |=> cur == INIT);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cur));
  assert_zero_splice_R5: assert property (@(posedge clk) disable iff (rst)
    (en && cur == WIDTH'(1)) |=> cur == '0);
  assert_zero_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (en && cur == '0) |=> cur == {1'b1, {(WIDTH-1){1'b0}}});
endmodule

// File: rtl/lfsr_match_flag.sv
module lfsr_match_flag #(
  parameter int               WIDTH  = 8,
  parameter logic [WIDTH-1:0] TARGET = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= (cur == TARGET);
  end

  assert_match_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (cur == TARGET) |=> hit);
  assert_match_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cur != TARGET) |=> !hit);
endmodule

// File: rtl/lfsr_fullcycle_counter.sv
module lfsr_fullcycle_counter #(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] TAPS        = 8'h1D,
  parameter int               START_INDEX = 5,
  parameter int               MATCH_INDEX = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] state,
  output logic             match
);
  localparam logic [WIDTH-1:0] START_STATE =
    WIDTH'(lfsr_seq_pkg::seq_at(WIDTH, 32'(TAPS), START_INDEX));
  localparam logic [WIDTH-1:0] MATCH_STATE =
    WIDTH'(lfsr_seq_pkg::seq_at(WIDTH, 32'(TAPS), MATCH_INDEX));

  logic [WIDTH-1:0] nxt;

  lfsr_next_logic #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
    .cur(state), .nxt(nxt));

  lfsr_state_reg #(.WIDTH(WIDTH), .INIT(START_STATE)) u_reg (
    .clk(clk), .rst(rst), .en(en), .nxt(nxt), .cur(state));

  lfsr_match_flag #(.WIDTH(WIDTH), .TARGET(MATCH_STATE)) u_match (
    .clk(clk), .rst(rst), .cur(state), .hit(match));

  // R3: an enabled step never leaves the register unchanged (no fixed point)
  assert_step_moves_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> state != $past(state));
endmodule

// File: tb/lfsr_fullcycle_counter_bench.sv
module lfsr_fullcycle_counter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] st8;
  logic [3:0] st4;
  logic       m8, m4;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lfsr_fullcycle_counter #(.WIDTH(8), .TAPS(8'h1D), .START_INDEX(5), .MATCH_INDEX(200))
    u_lfsr_fullcycle_counter (.clk(clk), .rst(rst), .en(en), .state(st8), .match(m8));
  lfsr_fullcycle_counter #(.WIDTH(4), .TAPS(4'h3), .START_INDEX(15), .MATCH_INDEX(15))
    u_lfsr_fullcycle_counter_w4 (.clk(clk), .rst(rst), .en(en), .state(st4), .match(m4));

  // behavioural reference: integers, per requirement R3
  function automatic int ref_step(int w, int taps, int s);
    int fb = 0;
    for (int i = 0; i < w; i++) if ((taps >> i) & 1) fb ^= (s >> i) & 1;
    if ((s >> 1) == 0) fb ^= 1;
    return (s >> 1) | (fb << (w - 1));
  endfunction
  function automatic int ref_at(int w, int taps, int k);
    int s = 0;
    for (int i = 0; i < k; i++) s = ref_step(w, taps, s);
    return s;
  endfunction

  int s8_start, s8_match, s4_start, s4_match;
  int mod8 = 0, mod4 = 0;
  bit mm8 = 0, mm4 = 0;

  initial begin
    s8_start = ref_at(8, 'h1D, 5);
    s8_match = ref_at(8, 'h1D, 200);
    s4_start = ref_at(4, 'h3, 15);
    s4_match = ref_at(4, 'h3, 15);
  end

  always @(posedge clk) begin
    if (rst) begin
      mod8 <= s8_start; mod4 <= s4_start; mm8 <= 0; mm4 <= 0;
    end else begin
      mm8 <= (mod8 == s8_match);
      mm4 <= (mod4 == s4_match);
      if (en) begin
        mod8 <= ref_step(8, 'h1D, mod8);
        mod4 <= ref_step(4, 'h3, mod4);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, sampled at the falling edge
  always @(negedge clk) if (!done) begin
    chk(int'(st8) == mod8, "R3 state8", st8, mod8);
    chk(int'(st4) == mod4, "R3 state4", st4, mod4);
    chk(m8 == mm8, "R6 match8", m8, mm8);
    chk(m4 == mm4, "R6 match4", m4, mm4);
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int seen8 [256];
  int seen4 [16];
  int ret8, ret4, hits8, bin_ok;
  int prev8;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk(int'(st8) == s8_start, "R1 start8", st8, s8_start);
    chk(int'(st4) == s4_start, "R1 start4", st4, s4_start);
    chk(m8 == 1'b0, "R1 match8 clear", m8, 0);
    // R2 hold with enable low
    repeat (4) @(negedge clk);
    chk(int'(st8) == s8_start, "R2 hold8", st8, s8_start);
    chk(int'(st4) == s4_start, "R2 hold4", st4, s4_start);
    // R5: 4-bit start is value 1, next must be 0 then 8
    en = 1'b1;
    @(negedge clk);
    chk(st4 == 4'd0, "R5 one to zero", st4, 0);
    @(negedge clk);
    chk(st4 == 4'd8, "R5 zero to msb", st4, 8);
    en = 1'b0;
    // back to start for full period run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    foreach (seen8[i]) seen8[i] = 0;
    foreach (seen4[i]) seen4[i] = 0;
    ret8 = -1; ret4 = -1; hits8 = 0; bin_ok = 1;
    en = 1'b1;
    for (int k = 1; k <= 256; k++) begin
      seen8[st8]++; seen4[st4]++;
      prev8 = st8;
      @(negedge clk);
      if (m8) hits8++;
      // R7: binary value 200 is not the translated compare state
      if (prev8 == 200 && s8_match != 200 && m8) bin_ok = 0;
      if (ret8 < 0 && int'(st8) == s8_start) ret8 = k;
      if (ret4 < 0 && int'(st4) == s4_start) ret4 = k;
    end
    en = 1'b0;
    chk(ret8 == 256, "R4 period8", ret8, 256);
    chk(ret4 == 16, "R4 period4", ret4, 16);
    for (int v = 0; v < 256; v++) chk(seen8[v] == 1, "R4 visit8", seen8[v], 1);
    for (int v = 0; v < 16; v++) chk(seen4[v] == 16, "R4 visit4", seen4[v], 16);
    chk(hits8 == 1, "R6 one match per period", hits8, 1);
    chk(bin_ok == 1, "R7 binary index not matched", bin_ok, 1);
    // irregular enable pattern, then mid-run reset
    for (int k = 0; k < 300; k++) begin
      en = (k % 3) != 1;
      @(negedge clk);
    end
    en = 1'b0;
    // R6 with enable low while parked on match state of 4-bit instance
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(m4 == 1'b1, "R6 match held while idle", m4, 1);
    rst = 1'b1; @(negedge clk);
    chk(int'(st8) == s8_start, "R1 reset mid-run", st8, s8_start);
    rst = 1'b0;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule